// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps a differential capacitor-DAC converter through one successive-approximation conversion. A level-sensitive convert input chooses the phase. While it is low the converter samples and every register in the block is held at zero. When it goes high the block drives a trial code with only the most significant conversion bit set. It then resolves one bit per qualified comparator-ready pulse, working from the top bit downward.

The DAC control word has 13 positions. Positions 12 down to 1 carry the twelve conversion bits. Position 0 is an extra range bit that is raised together with the last decision. An internal strobe generator passes a one-hot token down the positions and emits one latch strobe per position. Each strobe stores the comparator decision in its bit and, in the same update, raises the next lower bit as the new trial. The comparator output is low when the positive DAC node is above the negative node, which means the trial is still below the input, so a low comparator output keeps the trial bit.

When all twelve decisions are made, a one-cycle done pulse is raised. The code then stays frozen until the convert input returns low. Dropping the convert input at any point aborts the conversion at once.

Top module: `sar_ctrl`

## Requirements
- R1: Whenever conv_i is sampled low at a rising clock edge, and during rst_ni low, dac_code_o, result_o and done_o become all zero.
- R2: At the first edge with conv_i high after a sampling phase, dac_code_o becomes 13'h1000: only position 12 is set, and result_o reads binary 1000_0000_0000.
- R3: A ready pulse counts only when rdy_i and rdy_valid_i are both high at an edge while a decision is pending. Any other edge leaves dac_code_o unchanged.
- R4: On a counted pulse with position i pending, bit i takes the inverse of cmp_i (cmp_i low keeps a 1). In the same edge, bit i-1 is set to 1, and the bits above i are unchanged.
- R5: Positions are resolved from 12 down to 1, one per counted pulse. After the twelfth decision, range bit 0 of dac_code_o is 1.
- R6: done_o is high for exactly one cycle, the cycle right after the edge that made the twelfth decision.
- R7: After done_o, dac_code_o and result_o hold their values, and ready pulses are ignored, for as long as conv_i stays high.
- R8: If conv_i falls during a conversion, all state clears at the next edge and no done_o is produced. The next rise of conv_i restarts from the R2 code.
- R9: With an ideal comparator (cmp_i high when result_o is greater than the analog target), the final result_o equals the target for every 12-bit value, including 0 and 4095.
- R10: result_o always equals dac_code_o[12:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Phase level: low = sample (held clear), high = convert |
| rdy_i | input | 1 | Comparator-ready pulse |
| rdy_valid_i | input | 1 | Qualifier for rdy_i |
| cmp_i | input | 1 | Comparator decision, low when positive node is higher |
| dac_code_o | output | 13 | Live DAC control code, position 0 is the range bit |
| result_o | output | 12 | Conversion bits, positions 12..1 of the code |
| done_o | output | 1 | One-cycle conversion-complete pulse |

## Verification
The sequencer is driven by an ideal comparator model against several kinds of target. The targets 0 and 4095 show that every trial is rejected or every trial is kept. The alternating patterns 0xAAA and 0x555, and the neighbours 0x800 and 0x7FF, separate errors in bit order from off-by-one errors in position. Random targets run with ready gaps and with unqualified ready pulses mixed in, which exposes any decision taken on a pulse that should not count. Separate runs abort a conversion midway and send ready pulses after done, to show the clear and freeze behaviour.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_CONVERT = 2'd1,
    PH_HOLD    = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  input  logic term_i,
  output logic start_o,
  output logic clr_o
);
  sar_phase_e phase_q;

  assign clr_o   = ~conv_i;
  assign start_o = conv_i && (phase_q == PH_SAMPLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SAMPLE;
    end else if (clr_o) begin
      phase_q <= PH_SAMPLE;
    end else begin
      unique case (phase_q)
        PH_SAMPLE:  phase_q <= PH_CONVERT;
        PH_CONVERT: if (term_i) phase_q <= PH_HOLD;
        PH_HOLD:    phase_q <= PH_HOLD;
        default:    phase_q <= PH_SAMPLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_strobe_gen.sv
module sar_strobe_gen #(
  parameter int POS = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           start_i,
  input  logic           adv_i,
  output logic [POS-1:0] stb_o
);
  localparam int TOP = POS - 1;

  logic [POS-1:0] tok_q;

  // token at 0 is the terminal slot: fires without a ready pulse
  assign stb_o = {tok_q[TOP:1] & {TOP{adv_i}}, tok_q[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tok_q <= '0;
    else if (clr_i)     tok_q <= '0;
    else if (start_i)   tok_q <= {1'b1, {TOP{1'b0}}};
    else if (tok_q[0])  tok_q <= '0;
    else if (adv_i)     tok_q <= tok_q >> 1;
  end
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int POS          = 13,
  parameter bit CMP_LOW_KEEP = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           start_i,
  input  logic           cmp_i,
  input  logic [POS-1:1] pick_i,
  output logic [POS-1:0] code_o
);
  localparam int TOP = POS - 1;

  logic keep;

  generate
    if (CMP_LOW_KEEP) begin : g_inv
      assign keep = ~cmp_i;
    end else begin : g_dir
      assign keep = cmp_i;
    end
  endgenerate

  for (genvar i = 0; i < POS; i++) begin : g_cell
    logic bit_q;
    assign code_o[i] = bit_q;
    if (i == 0) begin : g_range
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= 1'b0;
        else if (clr_i)     bit_q <= 1'b0;
        else if (pick_i[1]) bit_q <= 1'b1;
      end
    end else if (i == TOP) begin : g_top
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= 1'b0;
        else if (clr_i)     bit_q <= 1'b0;
        else if (start_i)   bit_q <= 1'b1;
        else if (pick_i[i]) bit_q <= keep;
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            bit_q <= 1'b0;
        else if (clr_i)         bit_q <= 1'b0;
        else if (start_i)       bit_q <= 1'b0;
        else if (pick_i[i])     bit_q <= keep;
        else if (pick_i[i+1])   bit_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N_BITS       = 12,
  parameter bit CMP_LOW_KEEP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              rdy_i,
  input  logic              rdy_valid_i,
  input  logic              cmp_i,
  output logic [N_BITS:0]   dac_code_o,
  output logic [N_BITS-1:0] result_o,
  output logic              done_o
);
  localparam int POS = N_BITS + 1;

  logic           start, clr, adv;
  logic [POS-1:0] stb;
  logic [POS-1:0] code;

  assign adv = rdy_i & rdy_valid_i;

  sar_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .conv_i  (conv_i),
    .term_i  (stb[0]),
    .start_o (start),
    .clr_o   (clr)
  );

  sar_strobe_gen #(.POS(POS)) u_stb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .start_i (start),
    .adv_i   (adv),
    .stb_o   (stb)
  );

  sar_bit_reg #(.POS(POS), .CMP_LOW_KEEP(CMP_LOW_KEEP)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .start_i (start),
    .cmp_i   (cmp_i),
    .pick_i  (stb[POS-1:1]),
    .code_o  (code)
  );

  assign dac_code_o = code;
  assign result_o   = code[POS-1:1];
  assign done_o     = stb[0];
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int N_BITS = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_i,
  input logic              rdy_i,
  input logic              rdy_valid_i,
  input logic              cmp_i,
  input logic [N_BITS:0]   dac_code_o,
  input logic [N_BITS-1:0] result_o,
  input logic              done_o
);
  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(conv_i) |-> (dac_code_o == '0 && !done_o));

  p_start_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && dac_code_o == '0) |=> (dac_code_o == {1'b1, {N_BITS{1'b0}}}));

  p_done_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dac_code_o[0]);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(conv_i) && $past(dac_code_o[0])) |-> $stable(dac_code_o));

  p_no_done_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(conv_i));

  p_ignored_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(conv_i) && !$past(rdy_i && rdy_valid_i) && $past(dac_code_o) != '0
     && !$past(dac_code_o[0]))
    |-> $stable(dac_code_o));
endmodule

bind sar_ctrl sar_ctrl_chk #(.N_BITS(N_BITS)) u_sar_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_i      (conv_i),
  .rdy_i       (rdy_i),
  .rdy_valid_i (rdy_valid_i),
  .cmp_i       (cmp_i),
  .dac_code_o  (dac_code_o),
  .result_o    (result_o),
  .done_o      (done_o)
);

// File: tb/sar_ctrl_test.sv
module sar_ctrl_test;
  localparam int NB = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv = 1'b0;
  logic          rdy = 1'b0;
  logic          rdy_valid = 1'b0;
  logic          cmp = 1'b0;
  logic [NB:0]   dac_code;
  logic [NB-1:0] result;
  logic          done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cyc = 0;

  // behavioural reference state
  int m_code = 0;
  int m_pos  = -1;
  int m_ph   = 0;

  sar_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .conv_i      (conv),
    .rdy_i       (rdy),
    .rdy_valid_i (rdy_valid),
    .cmp_i       (cmp),
    .dac_code_o  (dac_code),
    .result_o    (result),
    .done_o      (done)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !conv) begin
      m_code = 0; m_pos = -1; m_ph = 0;
    end else if (m_ph == 0) begin
      m_code = 1 << NB; m_pos = NB; m_ph = 1;
    end else if (m_ph == 1) begin
      if (m_pos == 0) begin
        m_pos = -1; m_ph = 2;
      end else if (rdy && rdy_valid) begin
        if (cmp) m_code = m_code & ~(1 << m_pos);
        m_code = m_code | (1 << (m_pos - 1));
        m_pos--;
      end
    end
  end

  // per-cycle comparison against the model (R4, R10 and the rest)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(int'(dac_code) == (m_code & 32'h1FFF), "R4 code", int'(dac_code), m_code);
      check(done == (m_pos == 0), "R6 done", int'(done), int'(m_pos == 0));
      check(result == dac_code[NB:1], "R10 view", int'(result), int'(dac_code[NB:1]));
    end
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      wrap_up();
    end
  end

  task automatic convert(input int target, input int gap, input bit junk, input int abort_after);
    int ndone = 0;
    int cnt   = 0;
    int adv_n = 0;
    logic [NB:0] prev;
    @(negedge clk);
    conv = 1'b1; rdy = 1'b0; rdy_valid = 1'b0; cmp = 1'b0;
    @(negedge clk);
    check(dac_code == 13'h1000, "R2 first trial", int'(dac_code), 32'h1000);
    for (int k = 0; k < 400; k++) begin
      bit go;
      go = (cnt % (gap + 1)) == 0;
      cnt++;
      prev = dac_code;
      cmp  = (int'(dac_code[NB:1]) > target);
      rdy       = go | junk;
      rdy_valid = go;
      if (abort_after >= 0 && adv_n == abort_after) begin
        conv = 1'b0; rdy = 1'b0; rdy_valid = 1'b0;
        @(negedge clk);
        check(dac_code == '0 && done == 1'b0, "R8 abort clear", int'(dac_code), 0);
        return;
      end
      @(negedge clk);
      if (go) adv_n++;
      if (!go && !done && dac_code[0] == 1'b0)
        check(dac_code == prev, "R3 unqualified pulse", int'(dac_code), int'(prev));
      if (done) begin
        ndone++;
        break;
      end
    end
    check(ndone == 1, "R6 done seen", ndone, 1);
    check(int'(result) == target, "R9 final code", int'(result), target);
    check(dac_code[0] == 1'b1, "R5 range bit", int'(dac_code[0]), 1);
    check(adv_n == NB, "R5 decision count", adv_n, NB);
    for (int k = 0; k < 4; k++) begin
      rdy = 1'b1; rdy_valid = 1'b1; cmp = k[0];
      @(negedge clk);
      check(int'(result) == target, "R7 frozen", int'(result), target);
      check(done == 1'b0, "R6 single pulse", int'(done), 0);
    end
    rdy = 1'b0; rdy_valid = 1'b0;
    conv = 1'b0;
    @(negedge clk);
    check(dac_code == '0 && result == '0 && done == 1'b0, "R1 sample clear",
          int'(dac_code), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dac_code == '0 && done == 1'b0, "R1 reset", int'(dac_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dac_code == '0 && result == '0, "R1 idle low", int'(dac_code), 0);

    convert(0,      0, 1'b0, -1);
    convert(4095,   0, 1'b0, -1);
    convert('h800,  1, 1'b1, -1);
    convert('h7FF,  2, 1'b0, -1);
    convert('hAAA,  0, 1'b0, -1);
    convert('h555,  3, 1'b1, -1);
    convert('h123,  0, 1'b0, 5);
    convert('hABC,  1, 1'b1, -1);
    convert(4095,   0, 1'b0, 11);
    convert(1,      0, 1'b0, -1);
    for (int t = 0; t < 40; t++)
      convert(int'($urandom_range(0, 4095)), int'($urandom_range(0, 2)),
              1'(t % 2), -1);
    wrap_up();
  end
endmodule